// File: doc/BRIEF.md
# DMA Channel Register Block

This block is the software-visible register front end of one channel of a descriptor-driven DMA controller. A host issues 32-bit word reads and writes on a simple request bus. The block decodes each access to a channel register and keeps the channel's control state: the enable and stop settings, the channel run state, and the pointer registers that it shares with the transfer engine.

The block also owns the channel's interrupt logic. The transfer engine raises cause bits with a pulse vector. Software masks those bits and clears them by writing ones to an acknowledge register. One level interrupt line is driven while any unmasked cause remains.

Writes to the stream-command and continue registers are turned into single-cycle request pulses for the engine. The engine reports its end-of-list flag and its command source, which appear in the status word. The engine can update three of the pointer registers and can put the channel into the running state. The block does no descriptor fetching and moves no data.

Top module: `dmac_chan_regs`

## Requirements
- R1: An access takes effect only when `bus_size` is 2 (word) and address bits [ADDR_W-1:13] equal CHANNEL_ID. Bits [12:8] are ignored, and bits [7:2] give the word index. Byte accesses (size 0), halfword accesses (size 1) and accesses to another channel write nothing and read 0. Reads of offsets that are not in the register map return 0.
- R2: Five 32-bit pointer registers read and write at byte offsets 0x00 (current data descriptor), 0x58 (saved data), 0x5C (saved buffer), 0x60 (group) and 0x7C (group down), and are driven on output ports. The engine writes the first three with `eng_wr_sel` = 1, 2 or 3. A bus write to the same register in the same cycle wins.
- R3: The configuration register at 0x84 holds enable in bit 0 and stop in bit 1. These bits read back in bits [1:0] and drive `chan_enable` and `chan_stop`.
- R4: `chan_state` is one-hot: reset = 3'b001, stopped = 3'b010, running = 3'b100. A configuration write with bit 0 clear sets reset; this takes precedence over the next case. Otherwise a configuration write with bit 1 set sets stopped. A configuration write with value 1 leaves the state unchanged. Outside a configuration write, `eng_start` sets running. A configuration write in the same cycle suppresses it.
- R5: The status word at 0x88 returns the state in bits [2:0], `eng_eol` in bit 5 and `eng_src` in bits [15:8]. All other bits read 0.
- R6: The raw cause register at 0x94 (INTR_W bits) sets its bits from `eng_intr_set`. A write to the acknowledge register at 0x90 clears the raw bits that are set in the written value. If a bit is set and acknowledged in the same cycle, it stays set. The acknowledge register always reads 0.
- R7: The mask register at 0x8C stores INTR_W bits. Offset 0x98 reads raw AND mask. `irq` is high exactly while raw AND mask is nonzero.
- R8: A stream-command write at 0x9C stores bits [9:0], which read back. In the next cycle, for one cycle only, three pulses are set from the written value:
  - `load_data_pulse` if bit 8 or bit 6 is set;
  - `start_pulse` if `load_data_pulse` is set and bit 5 is set;
  - `load_ctx_pulse` if bit 9 is set.
- R9: The command register at 0x80 stores bit 0. A write with bit 0 set gives a one-cycle `cont_pulse` in the next cycle. A write with bit 0 clear gives no pulse.
- R10: After reset, all registers are 0, `chan_state` is the reset code, and `irq` and all pulses are low.
- R11: Read data is registered. It appears on `bus_rdata` in the cycle after the read request and holds until the next read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_wr_sel | input | 2 | Engine pointer update: 0 none, 1 data, 2 saved data, 3 saved buffer |
| eng_wr_val | input | 32 | Engine pointer value |
| eng_start | input | 1 | Engine puts channel in running state |
| eng_eol | input | 1 | Engine end-of-list flag |
| eng_src | input | 8 | Engine stream command source |
| eng_intr_set | input | INTR_W | Interrupt cause set pulses |
| cur_data_ptr | output | 32 | Current data descriptor pointer |
| saved_data_ptr | output | 32 | Saved data pointer |
| saved_buf_ptr | output | 32 | Saved buffer pointer |
| group_ptr | output | 32 | Group pointer |
| group_down_ptr | output | 32 | Group-down pointer |
| chan_enable | output | 1 | Configuration enable bit |
| chan_stop | output | 1 | Configuration stop bit |
| chan_state | output | 3 | One-hot channel state |
| irq | output | 1 | Level interrupt |
| cont_pulse | output | 1 | Continue request |
| load_data_pulse | output | 1 | Data descriptor load request |
| start_pulse | output | 1 | Start-after-load request |
| load_ctx_pulse | output | 1 | Context descriptor load request |

## Verification
The engine's interrupt set pulse and a software acknowledge write can hit the same cause bit in the same cycle. The bench provokes this with a directed case and with a seeded random run. In the random run, set vectors are driven during acknowledge, mask and raw-read accesses. A bench model, in which a set overrides a clear, judges every cycle's `irq` and each raw readback. A second pair, an engine pointer update against a bus write to the same register, is driven directly, and the bus value must survive.

// File: rtl/dmac_reg_pkg.sv
package dmac_reg_pkg;

    typedef enum logic [2:0] {
        CH_RST  = 3'b001,
        CH_STOP = 3'b010,
        CH_RUN  = 3'b100
    } ch_state_e;

    typedef enum logic [3:0] {
        REG_NONE, REG_DATA, REG_SDATA, REG_SBUF, REG_GROUP, REG_GDOWN,
        REG_CMD, REG_CFG, REG_STAT, REG_MASK, REG_ACK, REG_RAW,
        REG_MASKED, REG_STREAM
    } reg_sel_e;

    typedef enum logic [1:0] {
        ENG_NONE  = 2'd0,
        ENG_DATA  = 2'd1,
        ENG_SDATA = 2'd2,
        ENG_SBUF  = 2'd3
    } eng_wr_e;

    typedef struct packed {
        logic load_data;
        logic start;
        logic load_ctx;
    } stream_req_t;

    localparam logic [1:0] SIZE_WORD = 2'd2;
    localparam int NUM_PTRS = 5;
    localparam int CH_LSB   = 13;

    // word index (byte offset / 4) to register
    function automatic reg_sel_e decode_index(input logic [5:0] idx);
        case (idx)
            6'd0:    return REG_DATA;
            6'd22:   return REG_SDATA;
            6'd23:   return REG_SBUF;
            6'd24:   return REG_GROUP;
            6'd31:   return REG_GDOWN;
            6'd32:   return REG_CMD;
            6'd33:   return REG_CFG;
            6'd34:   return REG_STAT;
            6'd35:   return REG_MASK;
            6'd36:   return REG_ACK;
            6'd37:   return REG_RAW;
            6'd38:   return REG_MASKED;
            6'd39:   return REG_STREAM;
            default: return REG_NONE;
        endcase
    endfunction

    function automatic stream_req_t decode_stream(input logic [9:0] v);
        stream_req_t r;
        r.load_data = v[8] | v[6];
        r.start     = (v[8] | v[6]) & v[5];
        r.load_ctx  = v[9];
        return r;
    endfunction

    function automatic logic [31:0] pack_status(input ch_state_e st,
                                                input logic eol,
                                                input logic [7:0] src);
        return {16'h0, src, 2'b00, eol, 2'b00, st};
    endfunction

    function automatic reg_sel_e ptr_reg(input int i);
        case (i)
            0:       return REG_DATA;
            1:       return REG_SDATA;
            2:       return REG_SBUF;
            3:       return REG_GROUP;
            default: return REG_GDOWN;
        endcase
    endfunction

    function automatic eng_wr_e ptr_eng(input int i);
        case (i)
            0:       return ENG_DATA;
            1:       return ENG_SDATA;
            2:       return ENG_SBUF;
            default: return ENG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dmac_bus_decode.sv
module dmac_bus_decode
    import dmac_reg_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CHANNEL_ID = 0
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_e          wr_sel,
    output reg_sel_e          rd_sel
);
    localparam int CH_W = ADDR_W - CH_LSB;

    logic     chan_hit;
    logic     word_hit;
    reg_sel_e target;

    assign chan_hit = (bus_addr[ADDR_W-1:CH_LSB] == CH_W'(CHANNEL_ID));
    assign word_hit = bus_valid && (bus_size == SIZE_WORD) && chan_hit;
    assign target   = decode_index(bus_addr[7:2]);

    always_comb begin
        wr_sel = REG_NONE;
        rd_sel = REG_NONE;
        if (word_hit) begin
            if (bus_write) wr_sel = target;
            else           rd_sel = target;
        end
    end
endmodule

// File: rtl/dmac_chan_state.sv
module dmac_chan_state
    import dmac_reg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cfg_wr,
    input  logic [1:0] cfg_val,
    input  logic      eng_start,
    output logic      cfg_en,
    output logic      cfg_stop,
    output ch_state_e state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_en   <= 1'b0;
            cfg_stop <= 1'b0;
            state    <= CH_RST;
        end else if (cfg_wr) begin
            cfg_en   <= cfg_val[0];
            cfg_stop <= cfg_val[1];
            if (!cfg_val[0])     state <= CH_RST;
            else if (cfg_val[1]) state <= CH_STOP;
        end else if (eng_start) begin
            state <= CH_RUN;
        end
    end
endmodule

// File: rtl/dmac_intr_ctrl.sv
module dmac_intr_ctrl #(
    parameter int INTR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_wr,
    input  logic              ack_wr,
    input  logic [INTR_W-1:0] wdata,
    input  logic [INTR_W-1:0] set_pulse,
    output logic [INTR_W-1:0] raw_q,
    output logic [INTR_W-1:0] mask_q,
    output logic              irq
);
    logic [INTR_W-1:0] clr_bits;

    assign clr_bits = ack_wr ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_bits) | set_pulse;
            if (mask_wr) mask_q <= wdata;
        end
    end

    assign irq = |(raw_q & mask_q);
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
    import dmac_reg_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CHANNEL_ID = 0,
    parameter int INTR_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [1:0]        eng_wr_sel,
    input  logic [31:0]       eng_wr_val,
    input  logic              eng_start,
    input  logic              eng_eol,
    input  logic [7:0]        eng_src,
    input  logic [INTR_W-1:0] eng_intr_set,
    output logic [31:0]       cur_data_ptr,
    output logic [31:0]       saved_data_ptr,
    output logic [31:0]       saved_buf_ptr,
    output logic [31:0]       group_ptr,
    output logic [31:0]       group_down_ptr,
    output logic              chan_enable,
    output logic              chan_stop,
    output logic [2:0]        chan_state,
    output logic              irq,
    output logic              cont_pulse,
    output logic              load_data_pulse,
    output logic              start_pulse,
    output logic              load_ctx_pulse
);
    reg_sel_e                     wr_sel;
    reg_sel_e                     rd_sel;
    ch_state_e                    state;
    eng_wr_e                      eng_sel;
    logic [NUM_PTRS-1:0][31:0]    ptr_q;
    logic [INTR_W-1:0]            raw_q;
    logic [INTR_W-1:0]            mask_q;
    logic                         cmd_q;
    logic [9:0]                   stream_q;
    stream_req_t                  req_q;
    logic [31:0]                  rd_val;

    assign eng_sel = eng_wr_e'(eng_wr_sel);

    dmac_bus_decode #(.ADDR_W(ADDR_W), .CHANNEL_ID(CHANNEL_ID)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_size  (bus_size),
        .bus_addr  (bus_addr),
        .wr_sel    (wr_sel),
        .rd_sel    (rd_sel)
    );

    dmac_chan_state u_state (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (wr_sel == REG_CFG),
        .cfg_val   (bus_wdata[1:0]),
        .eng_start (eng_start),
        .cfg_en    (chan_enable),
        .cfg_stop  (chan_stop),
        .state     (state)
    );

    dmac_intr_ctrl #(.INTR_W(INTR_W)) u_intr (
        .clk       (clk),
        .rst       (rst),
        .mask_wr   (wr_sel == REG_MASK),
        .ack_wr    (wr_sel == REG_ACK),
        .wdata     (bus_wdata[INTR_W-1:0]),
        .set_pulse (eng_intr_set),
        .raw_q     (raw_q),
        .mask_q    (mask_q),
        .irq       (irq)
    );

    // pointer registers: bus write has priority over engine update
    for (genvar gi = 0; gi < NUM_PTRS; gi++) begin : g_ptr
        localparam reg_sel_e BUS_SEL = ptr_reg(gi);
        localparam eng_wr_e  ENG_SEL = ptr_eng(gi);
        always_ff @(posedge clk) begin
            if (rst)
                ptr_q[gi] <= '0;
            else if (wr_sel == BUS_SEL)
                ptr_q[gi] <= bus_wdata;
            else if (ENG_SEL != ENG_NONE && eng_sel == ENG_SEL)
                ptr_q[gi] <= eng_wr_val;
        end
    end

    assign cur_data_ptr   = ptr_q[0];
    assign saved_data_ptr = ptr_q[1];
    assign saved_buf_ptr  = ptr_q[2];
    assign group_ptr      = ptr_q[3];
    assign group_down_ptr = ptr_q[4];
    assign chan_state     = state;

    // command registers and request pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q      <= 1'b0;
            stream_q   <= '0;
            req_q      <= '0;
            cont_pulse <= 1'b0;
        end else begin
            cont_pulse <= (wr_sel == REG_CMD) && bus_wdata[0];
            req_q      <= (wr_sel == REG_STREAM) ? decode_stream(bus_wdata[9:0])
                                                 : '0;
            if (wr_sel == REG_CMD)    cmd_q    <= bus_wdata[0];
            if (wr_sel == REG_STREAM) stream_q <= bus_wdata[9:0];
        end
    end

    assign load_data_pulse = req_q.load_data;
    assign start_pulse     = req_q.start;
    assign load_ctx_pulse  = req_q.load_ctx;

    // read path
    always_comb begin
        case (rd_sel)
            REG_DATA:   rd_val = ptr_q[0];
            REG_SDATA:  rd_val = ptr_q[1];
            REG_SBUF:   rd_val = ptr_q[2];
            REG_GROUP:  rd_val = ptr_q[3];
            REG_GDOWN:  rd_val = ptr_q[4];
            REG_CMD:    rd_val = {31'h0, cmd_q};
            REG_CFG:    rd_val = {30'h0, chan_stop, chan_enable};
            REG_STAT:   rd_val = pack_status(state, eng_eol, eng_src);
            REG_MASK:   rd_val = 32'(mask_q);
            REG_RAW:    rd_val = 32'(raw_q);
            REG_MASKED: rd_val = 32'(raw_q & mask_q);
            REG_STREAM: rd_val = {22'h0, stream_q};
            default:    rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_valid && !bus_write)
            bus_rdata <= rd_val;
    end
endmodule

// File: rtl/dmac_chan_regs_chk.sv
module dmac_chan_regs_chk
    import dmac_reg_pkg::*;
#(
    parameter int INTR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input reg_sel_e          wr_sel,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [1:0]        bus_size,
    input logic [31:0]       bus_wdata,
    input logic [INTR_W-1:0] eng_intr_set,
    input logic [INTR_W-1:0] raw_q,
    input logic [2:0]        chan_state,
    input logic              chan_enable,
    input logic              chan_stop,
    input logic              load_ctx_pulse,
    input logic              cont_pulse
);
    a_r4_state_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(chan_state) == 1);

    a_r4_disable_to_reset: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == REG_CFG && !bus_wdata[0]) |=> chan_state == 3'b001);

    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|eng_intr_set) |=> ((raw_q & $past(eng_intr_set)) == $past(eng_intr_set)));

    a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == REG_ACK && eng_intr_set == '0)
        |=> ((raw_q & $past(bus_wdata[INTR_W-1:0])) == '0));

    a_r8_ctx_pulse: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == REG_STREAM && bus_wdata[9]) |=> load_ctx_pulse);

    a_r9_no_spurious_continue: assert property (@(posedge clk) disable iff (rst)
        !(wr_sel == REG_CMD && bus_wdata[0]) |=> !cont_pulse);

    a_r1_subword_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_size != SIZE_WORD)
        |=> $stable({chan_enable, chan_stop}));
endmodule

bind dmac_chan_regs dmac_chan_regs_chk #(.INTR_W(INTR_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .wr_sel         (wr_sel),
    .bus_valid      (bus_valid),
    .bus_write      (bus_write),
    .bus_size       (bus_size),
    .bus_wdata      (bus_wdata),
    .eng_intr_set   (eng_intr_set),
    .raw_q          (raw_q),
    .chan_state     (chan_state),
    .chan_enable    (chan_enable),
    .chan_stop      (chan_stop),
    .load_ctx_pulse (load_ctx_pulse),
    .cont_pulse     (cont_pulse)
);

// File: tb/dmac_chan_regs_test.sv
module dmac_chan_regs_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int ADDR_W = 16;
    localparam int INTR_W = 4;
    localparam logic [15:0] BASE = 16'h2000;  // channel 1

    localparam logic [7:0] O_DATA = 8'h00, O_SDATA = 8'h58, O_SBUF = 8'h5C,
        O_GROUP = 8'h60, O_GDOWN = 8'h7C, O_CMD = 8'h80, O_CFG = 8'h84,
        O_STAT = 8'h88, O_MASK = 8'h8C, O_ACK = 8'h90, O_RAW = 8'h94,
        O_MASKED = 8'h98, O_STREAM = 8'h9C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [1:0] bus_size = 2'd2;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [1:0] eng_wr_sel = 2'd0;
    logic [31:0] eng_wr_val = '0;
    logic eng_start = 1'b0, eng_eol = 1'b0;
    logic [7:0] eng_src = '0;
    logic [INTR_W-1:0] eng_intr_set = '0;
    logic [31:0] cur_data_ptr, saved_data_ptr, saved_buf_ptr, group_ptr, group_down_ptr;
    logic chan_enable, chan_stop, irq, cont_pulse, load_data_pulse, start_pulse, load_ctx_pulse;
    logic [2:0] chan_state;

    int checks = 0;
    int fails  = 0;
    logic [INTR_W-1:0] raw_m = '0;
    logic [INTR_W-1:0] mask_m = '0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    dmac_chan_regs #(.ADDR_W(ADDR_W), .CHANNEL_ID(1), .INTR_W(INTR_W)) uut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] addr, input logic [31:0] data, input logic [1:0] size);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = addr; bus_wdata = data; bus_size = size;
        cyc();
        bus_valid = 1'b0; bus_write = 1'b0; bus_size = 2'd2;
    endtask

    task automatic rd(input logic [15:0] addr, input logic [1:0] size, output logic [31:0] val);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = addr; bus_size = size;
        cyc();
        val = bus_rdata;
        bus_valid = 1'b0; bus_size = 2'd2;
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) cyc();
        rst = 1'b0;
        cyc();

        // R10 reset state
        check("R10 state", 32'(chan_state), 32'h1);
        check("R10 irq", 32'(irq), 32'h0);
        check("R10 pulses", {28'h0, cont_pulse, load_data_pulse, start_pulse, load_ctx_pulse}, 32'h0);
        rd(BASE | O_CFG, 2'd2, rv);   check("R10 cfg read", rv, 32'h0);
        rd(BASE | O_STAT, 2'd2, rv);  check("R5 reset status", rv, 32'h1);

        // R2 pointers
        wr(BASE | O_GROUP, 32'hCAFE_0060, 2'd2);
        rd(BASE | O_GROUP, 2'd2, rv); check("R2 group read", rv, 32'hCAFE_0060);
        check("R2 group port", group_ptr, 32'hCAFE_0060);
        wr(BASE | O_GDOWN, 32'h1234_007C, 2'd2);
        check("R2 gdown port", group_down_ptr, 32'h1234_007C);
        wr(BASE | O_DATA, 32'hD00D_0000, 2'd2);
        rd(BASE | O_DATA, 2'd2, rv);  check("R2 data read", rv, 32'hD00D_0000);
        eng_wr_sel = 2'd3; eng_wr_val = 32'hBEEF_0003;
        cyc();
        eng_wr_sel = 2'd0;
        check("R2 engine sbuf", saved_buf_ptr, 32'hBEEF_0003);
        eng_wr_sel = 2'd2; eng_wr_val = 32'hAAAA_AAAA;
        wr(BASE | O_SDATA, 32'h5555_0058, 2'd2);
        eng_wr_sel = 2'd0;
        check("R2 bus wins", saved_data_ptr, 32'h5555_0058);
        rd(BASE | O_SBUF, 2'd2, rv);  check("R2 sbuf read", rv, 32'hBEEF_0003);

        // R1 decode corner cases
        wr(BASE | O_CFG, 32'h3, 2'd0);
        check("R1 byte write ignored", {30'h0, chan_stop, chan_enable}, 32'h0);
        wr(BASE | O_CFG, 32'h3, 2'd1);
        check("R1 half write ignored", {30'h0, chan_stop, chan_enable}, 32'h0);
        wr(16'h0000 | O_CFG, 32'h1, 2'd2);
        check("R1 other channel write ignored", 32'(chan_enable), 32'h0);
        rd(16'h0000 | O_GROUP, 2'd2, rv); check("R1 other channel read", rv, 32'h0);
        rd(BASE | O_GROUP, 2'd1, rv);     check("R1 half read", rv, 32'h0);
        rd(BASE | 8'h04, 2'd2, rv);       check("R1 undefined offset", rv, 32'h0);
        rd(BASE | 16'h0100 | O_GROUP, 2'd2, rv); check("R1 alias bits 12:8", rv, 32'hCAFE_0060);

        // R3/R4 configuration and state
        wr(BASE | O_CFG, 32'h1, 2'd2);
        check("R3 enable", 32'(chan_enable), 32'h1);
        check("R4 enable keeps state", 32'(chan_state), 32'h1);
        eng_start = 1'b1; cyc(); eng_start = 1'b0;
        check("R4 run", 32'(chan_state), 32'h4);
        eng_start = 1'b1; wr(BASE | O_CFG, 32'h1, 2'd2); eng_start = 1'b0;
        check("R4 cfg write suppresses start", 32'(chan_state), 32'h4);
        wr(BASE | O_CFG, 32'h3, 2'd2);
        check("R4 stop", 32'(chan_state), 32'h2);
        rd(BASE | O_CFG, 2'd2, rv);   check("R3 cfg readback", rv, 32'h3);
        eng_start = 1'b1; wr(BASE | O_CFG, 32'h2, 2'd2); eng_start = 1'b0;
        check("R4 disable wins over stop", 32'(chan_state), 32'h1);
        check("R3 stop bit port", 32'(chan_stop), 32'h1);

        // R5 status word
        eng_start = 1'b1; cyc(); eng_start = 1'b0;
        eng_eol = 1'b1; eng_src = 8'hA5;
        rd(BASE | O_STAT, 2'd2, rv);  check("R5 status", rv, 32'h0000_A524);
        eng_eol = 1'b0; eng_src = 8'h00;

        // R6/R7 directed
        eng_intr_set = 4'b1010; cyc(); eng_intr_set = '0;
        rd(BASE | O_RAW, 2'd2, rv);   check("R6 raw set", rv, 32'hA);
        check("R7 masked off no irq", 32'(irq), 32'h0);
        wr(BASE | O_ACK, 32'h2, 2'd2);
        rd(BASE | O_RAW, 2'd2, rv);   check("R6 ack clears", rv, 32'h8);
        rd(BASE | O_ACK, 2'd2, rv);   check("R6 ack reads zero", rv, 32'h0);
        eng_intr_set = 4'b1000; wr(BASE | O_ACK, 32'h8, 2'd2); eng_intr_set = '0;
        rd(BASE | O_RAW, 2'd2, rv);   check("R6 set beats ack", rv, 32'h8);
        wr(BASE | O_MASK, 32'h8, 2'd2);
        check("R7 irq on", 32'(irq), 32'h1);
        rd(BASE | O_MASKED, 2'd2, rv); check("R7 masked read", rv, 32'h8);
        wr(BASE | O_ACK, 32'hF, 2'd2);
        check("R7 irq off after ack", 32'(irq), 32'h0);
        raw_m = '0; mask_m = 4'h8;

        // R6/R7 random: set pulses colliding with ack and mask writes
        for (int i = 0; i < 400; i++) begin
            logic [3:0] s;
            logic [3:0] v;
            int op;
            logic [31:0] exp_raw;
            s  = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
            op = int'($urandom % 4);
            v  = 4'($urandom);
            exp_raw = 32'(raw_m);
            eng_intr_set = s;
            bus_valid = (op != 0);
            bus_write = (op == 1 || op == 2);
            bus_size  = 2'd2;
            bus_addr  = BASE | ((op == 1) ? O_ACK : (op == 2) ? O_MASK : O_RAW);
            bus_wdata = {28'($urandom), v};
            cyc();
            bus_valid = 1'b0; bus_write = 1'b0; eng_intr_set = '0;
            raw_m = (op == 1) ? ((raw_m & ~v) | s) : (raw_m | s);
            if (op == 2) mask_m = v;
            check("R7 random irq", 32'(irq), 32'(|(raw_m & mask_m)));
            if (op == 3) check("R6 random raw", bus_rdata, exp_raw);
        end

        // R8 stream command
        wr(BASE | O_STREAM, 32'hFFFF_F160, 2'd2);
        check("R8 load+start pulses", {29'h0, load_data_pulse, start_pulse, load_ctx_pulse}, 32'h6);
        cyc();
        check("R8 pulses one cycle", {29'h0, load_data_pulse, start_pulse, load_ctx_pulse}, 32'h0);
        rd(BASE | O_STREAM, 2'd2, rv); check("R8 stream readback", rv, 32'h160);
        wr(BASE | O_STREAM, 32'h200, 2'd2);
        check("R8 ctx pulse", {29'h0, load_data_pulse, start_pulse, load_ctx_pulse}, 32'h1);
        wr(BASE | O_STREAM, 32'h020, 2'd2);
        check("R8 burst alone none", {29'h0, load_data_pulse, start_pulse, load_ctx_pulse}, 32'h0);
        wr(BASE | O_STREAM, 32'h040, 2'd2);
        check("R8 bit6 load only", {29'h0, load_data_pulse, start_pulse, load_ctx_pulse}, 32'h4);

        // R9 continue command
        wr(BASE | O_CMD, 32'h1, 2'd2);
        check("R9 continue pulse", 32'(cont_pulse), 32'h1);
        cyc();
        check("R9 pulse one cycle", 32'(cont_pulse), 32'h0);
        rd(BASE | O_CMD, 2'd2, rv);   check("R9 cmd readback", rv, 32'h1);
        wr(BASE | O_CMD, 32'h0, 2'd2);
        check("R9 no pulse on zero", 32'(cont_pulse), 32'h0);

        // R11 read data holds when idle
        rd(BASE | O_GDOWN, 2'd2, rv);
        cyc(); cyc();
        check("R11 rdata holds", bus_rdata, 32'h1234_007C);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule